// File: doc/BRIEF.md
# Clock-Enable Control Slave on a Two-Wire Bus

This block is the control plane of a clock fan-out buffer with twelve differential output pairs. It is a slave on a two-wire serial bus with SCL and SDA. SDA is open-drain, so the block has separate input, output and output-enable signals for it. A fast system clock oversamples both bus lines. The block holds one enable bit for each output pair and one bit that selects the stronger output drive. It combines the enables with an active-low power-down pin and produces the per-pair enable and high-impedance controls for the analog output stage.

Transfers use a block protocol. After its address, a write carries a command byte and a length byte. The slave acknowledges both and throws their values away. Data bytes follow, and they land on register positions 0, 1, 2 and so on. A read returns a fixed length value of 0x09 first, then the register bytes in ascending order. Only positions 6 and 7 hold state. Every other position reads as zero and ignores writes. Once nine data bytes have been read, the slave returns 0xFF until the master stops acknowledging. The bus runs at the 100 kbit/s standard rate, which is far below the system clock.

Top module: `clkfan_ctl_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), which carry the 7-bit address 1101001. For any other address it leaves SDA released for the rest of that transfer, and the data in that transfer changes nothing.
- R2: In a write, the slave acknowledges the two bytes after the address, a command byte and a length byte, and discards them. The next byte written goes to position 0, and the positions then increment by one per byte.
- R3: A read returns 0x09 as its first byte, then the data of positions 0, 1, 2 and so on in order.
- R4: In position 7, bit k enables pair k for k = 0..7. In position 6, bits 3..0 enable pairs 11..8. A bit value of 1 means enabled. After reset all twelve pairs are enabled.
- R5: Bit 5 of position 6 selects enhanced drive on drive_boost and resets to 0. Bits 7, 6 and 4 of position 6 read as 0 and ignore writes.
- R6: Positions 0 to 5 and position 8 acknowledge writes, keep no state and read as 0x00.
- R7: After the length byte and nine data bytes, each further byte in the same read is 0xFF.
- R8: When the master does not acknowledge a byte the slave sent, the slave releases SDA. It keeps SDA released until the next START.
- R9: While pwr_dn_n is low, every pair_en bit is 0 and every pair_hiz bit is 1, whatever the register contents. While pwr_dn_n is high, pair_hiz is 0 and pair_en follows the register enables.
- R10: A START or repeated START aborts the transfer in progress, and a byte cut short by it is not written. A STOP returns the slave to idle with SDA released.
- R11: After reset SDA is released, all pairs are enabled and drive_boost is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_o | output | 1 | Value driven on SDA when enabled, always 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| pwr_dn_n | input | 1 | Active-low power-down for all outputs |
| pair_en | output | 12 | Per-pair clock enable after power-down gating |
| pair_hiz | output | 12 | Per-pair high-impedance control |
| drive_boost | output | 1 | Enhanced output drive select |

## Verification
A wrong byte position or a wrong length state shows up on SDA within the next byte the slave sends. It appears as a shifted or wrong value in readback, and the same fault moves the enables of the wrong pair on pair_en as soon as a write ends. A protocol state that fails to return to idle on a NACK, STOP or START shows on SDA one bit time later: the slave pulls SDA low where the line should stay high. The checks therefore compare pair_en right after each STOP, every byte read back, and the level of SDA on the clock pulses after a NACK.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
  localparam int PAIRS = 12;
  localparam logic [7:0] LEN_VAL = 8'h09;
  localparam logic [3:0] LAST_POS = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT
  } bus_st_e;

  // Byte position counter that stops at its top value.
  function automatic logic [3:0] sat_inc(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction

  // Byte sent at read position pos: length first, then data, then 0xFF.
  function automatic logic [7:0] tx_pick(input logic [3:0] pos, input logic [7:0] data);
    if (pos == 4'd0) return LEN_VAL;
    else if (pos <= LAST_POS) return data;
    else return 8'hFF;
  endfunction

  // Readback of a register position.
  function automatic logic [7:0] reg_view(input logic [3:0] idx, input logic [PAIRS-1:0] en,
                                          input logic boost);
    case (idx)
      4'd6:    return {2'b00, boost, 1'b0, en[11:8]};
      4'd7:    return en[7:0];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sbus_front.sv
module sbus_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_c     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_c & ~scl_d;
  assign scl_fall  = ~scl_c & scl_d;
  assign start_evt = scl_c & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_c & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine import clkbuf_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic [3:0] rd_idx,
  output logic       wr_stb,
  output logic [3:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  bus_st_e    st;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       is_addr, rd_mode, mack;
  logic [3:0] bidx;
  logic       byte_done, addr_hit;
  logic [3:0] nb;

  assign byte_done = (st == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (sh[7:1] == DEV_ADDR);
  assign nb        = sat_inc(bidx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= '0;
      is_addr <= 1'b0; rd_mode <= 1'b0; bidx <= '0; mack <= 1'b0;
    end else if (start_evt) begin
      st <= S_RX; bitcnt <= '0; is_addr <= 1'b1; bidx <= '0;
    end else if (stop_evt) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (is_addr) begin
              st      <= addr_hit ? S_RX_ACK : S_WAIT;
              rd_mode <= sh[0];
            end else begin
              st   <= S_RX_ACK;
              bidx <= nb;
            end
          end
        end
        S_RX_ACK: if (scl_fall) begin
          bitcnt  <= '0;
          is_addr <= 1'b0;
          if (is_addr && rd_mode) begin
            st <= S_TX;
            sh <= tx_pick(4'd0, rd_data);
          end else begin
            st <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 4'd7) st <= S_TX_ACK;
          else begin
            sh     <= {sh[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        S_TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              st <= S_TX; bitcnt <= '0; bidx <= nb;
              sh <= tx_pick(nb, rd_data);
            end else begin
              st <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_idx  = bidx;
  assign wr_stb  = byte_done && !is_addr && (bidx >= 4'd2) && !start_evt && !stop_evt;
  assign wr_idx  = bidx - 4'd2;
  assign wr_data = sh;
  assign sda_oe  = (st == S_RX_ACK) || ((st == S_TX) && !sh[7]);

  // R10
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == S_RX && bitcnt == 4'd0 && is_addr));
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (st == S_IDLE && !sda_oe));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX_ACK && scl_fall && !mack && !start_evt && !stop_evt) |=> !sda_oe);
  // R7
  tx_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |-> (bitcnt <= 4'd7));
endmodule

// File: rtl/clk_regbank.sv
module clk_regbank import clkbuf_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [3:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       rd_idx,
  output logic [7:0]       rd_data,
  output logic [PAIRS-1:0] en_bits,
  output logic             boost
);
  logic [PAIRS-1:0] en_q;
  logic             boost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '1;
      boost_q <= 1'b0;
    end else if (wr_stb) begin
      if (wr_idx == 4'd7) en_q[7:0] <= wr_data;
      if (wr_idx == 4'd6) begin
        en_q[11:8] <= wr_data[3:0];
        boost_q    <= wr_data[5];
      end
    end
  end

  assign rd_data = reg_view(rd_idx, en_q, boost_q);
  assign en_bits = en_q;
  assign boost   = boost_q;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb || (wr_idx != 4'd6 && wr_idx != 4'd7)) |=> ($stable(en_q) && $stable(boost_q)));
endmodule

// File: rtl/clkfan_ctl_slave.sv
module clkfan_ctl_slave import clkbuf_pkg::*; #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_o,
  output logic             sda_oe,
  input  logic             pwr_dn_n,
  output logic [PAIRS-1:0] pair_en,
  output logic [PAIRS-1:0] pair_hiz,
  output logic             drive_boost
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] rd_data, wr_data;
  logic [3:0] rd_idx, wr_idx;
  logic wr_stb;
  logic [PAIRS-1:0] en_bits;

  sbus_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt));

  sbus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe));

  clk_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .en_bits(en_bits), .boost(drive_boost));

  assign sda_o = 1'b0;

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign pair_en[g]  = en_bits[g] & pwr_dn_n;
    assign pair_hiz[g] = ~pwr_dn_n;
  end

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en & ~en_bits) == '0);
  // R9
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |-> (pair_hiz == '1 && pair_en == '0));
endmodule

// File: tb/sim_clkfan_ctl_slave.sv
module sim_clkfan_ctl_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1, pwr_dn_n = 1'b1;
  logic sda_o, sda_oe, drive_boost;
  logic [11:0] pair_en, pair_hiz;
  wire sda_line = (sda_oe ? sda_o : 1'b1) & msda;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  clkfan_ctl_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_o(sda_o),
    .sda_oe(sda_oe), .pwr_dn_n(pwr_dn_n), .pair_en(pair_en), .pair_hiz(pair_hiz),
    .drive_boost(drive_boost));

  // {byte6, byte7, expected pair_en, expected boost, expected readback of position 6}
  localparam logic [36:0] VEC [0:3] = '{
    {8'h0F, 8'hFF, 12'hFFF, 1'b0, 8'h0F},
    {8'hF5, 8'hA5, 12'h5A5, 1'b1, 8'h25},
    {8'h00, 8'h00, 12'h000, 1'b0, 8'h00},
    {8'hDA, 8'h3C, 12'hA3C, 1'b0, 8'h0A}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; tick(Q); scl = 1'b1; tick(Q); msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(Q); scl = 1'b1; tick(Q); msda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    msda = b; tick(Q); scl = 1'b1; tick(Q);
    @(negedge clk) s = sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~ack, s);
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] b6, input logic [7:0] b7,
                          input logic exp_ack);
    logic a;
    bus_start();
    send_byte(addr, a); chk("R1 address ack", a, exp_ack);
    send_byte(8'h07, a); if (exp_ack) chk("R2 command ack", a, 1);
    send_byte(8'h02, a); if (exp_ack) chk("R2 length ack", a, 1);
    for (int k = 0; k < 9; k++) begin
      send_byte(k == 6 ? b6 : (k == 7 ? b7 : 8'hAB), a);
      if (exp_ack) chk("R6 data ack", a, 1);
      else chk("R1 no ack on foreign address", a, 0);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] e6, input logic [7:0] e7);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a); chk("R1 read address ack", a, 1);
    recv_byte(1'b1, d); chk("R3 length byte", d, 8'h09);
    for (int k = 0; k < 9; k++) begin
      recv_byte(1'b1, d);
      if (k == 6) chk("R5 readback position 6", d, e6);
      else if (k == 7) chk("R4 readback position 7", d, e7);
      else chk("R6 reserved reads zero", d, 8'h00);
    end
    recv_byte(1'b0, d); chk("R7 past end 0xFF", d, 8'hFF);
    tick(Q);
    @(negedge clk) chk("R8 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] d;
    tick(4); rst_n = 1'b1; tick(4);
    @(negedge clk);
    chk("R11 sda released", sda_oe, 0);
    chk("R11 all enabled", pair_en, 12'hFFF);
    chk("R11 boost off", drive_boost, 0);
    chk("R9 hiz low when powered", pair_hiz, 12'h000);
    do_read(8'h0F, 8'hFF);

    for (int v = 0; v < 4; v++) begin
      do_write(8'hD2, VEC[v][36:29], VEC[v][28:21], 1'b1);
      tick(Q);
      @(negedge clk);
      chk("R4 pair enables", pair_en, VEC[v][20:9]);
      chk("R5 drive boost", drive_boost, VEC[v][8]);
      do_read(VEC[v][7:0], VEC[v][28:21]);
    end

    // R1: a foreign address is ignored
    do_write(8'hA4, 8'h00, 8'h00, 1'b0);
    tick(Q); @(negedge clk);
    chk("R1 foreign write ignored", pair_en, 12'hA3C);

    // R9: power-down overrides
    pwr_dn_n = 1'b0; tick(2); @(negedge clk);
    chk("R9 power-down disables", pair_en, 12'h000);
    chk("R9 power-down hiz", pair_hiz, 12'hFFF);
    pwr_dn_n = 1'b1; tick(2); @(negedge clk);
    chk("R9 power restored", pair_en, 12'hA3C);
    chk("R9 hiz released", pair_hiz, 12'h000);

    // R10: repeated START mid-byte aborts the write
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h07, a); send_byte(8'h02, a);
    for (int k = 0; k < 6; k++) send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_start();
    send_byte(8'hD3, a); chk("R10 fresh address after restart", a, 1);
    recv_byte(1'b0, d); chk("R10 read restarts at length", d, 8'h09);
    bus_stop();
    tick(Q); @(negedge clk);
    chk("R10 partial byte not written", pair_en, 12'hA3C);
    chk("R10 stop releases sda", sda_oe, 0);

    // R8: after a NACK the slave stays off the bus
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, d);
    begin
      int low = 0;
      for (int i = 0; i < 9; i++) begin
        clk_bit(1'b1, s);
        if (!s) low++;
      end
      chk("R8 sda stays released", low, 0);
    end
    bus_stop();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule